// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block decides which power state a small microcontroller core enters when it runs its sleep instruction, and which state it returns to on a wakeup event. It keeps the current state among six values: active, subactive, sleep, subsleep, standby and watch. From that state it drives the enables for the main clock and the sub clock.

Software reaches two 8-bit control registers over a simple select/write-enable register bus. The power-control register carries the bits that steer state selection: a software-standby select, a low-speed-on flag, a 3-bit standby-timer select, a 2-bit clock-select field and one reserved bit. The auxiliary register is plain storage.

When the core raises its sleep-executed strobe, the controller combines the software-standby bit, the current run mode and a watch-timer-enabled input to pick one of four low-power outcomes. A wakeup strobe leaves a low-power state. The target of that exit depends on the state being left and, for watch, on the low-speed-on flag. Oscillators, settling-time counting and clock division are outside this block.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, state_o is active and reads return 0x07 at 0xFFF0 and 0xF0 at 0xFFF1. The state_o encoding is: 0 active, 1 subactive, 2 sleep, 3 subsleep, 4 standby, 5 watch.
- R2: A cycle with sel_i=1 and we_i=1 writes wdata_i into the addressed register at the next rising edge. The power-control register is at 0xFFF0. rdata_o is combinational on addr_i. Any other address reads 0x00 and a write to it changes nothing. With sel_i=0 a write has no effect.
- R3: In the power-control register, bit 2 is reserved. Writes to it are ignored and reads always return 1. The other fields are: bit 7 software-standby select, bit 3 low-speed-on, bits 6:4 standby-timer select, bits 1:0 clock select.
- R4: The auxiliary register at 0xFFF1 is a fully writable 8-bit register with reset value 0xF0. Writing it does not change the power-control register.
- R5: A sleep strobe in active with the software-standby bit at 0 moves the state to sleep at the next edge.
- R6: A sleep strobe in subactive with the software-standby bit at 0 moves the state to subsleep.
- R7: A sleep strobe in active with the software-standby bit at 1 moves the state to watch when watch_tmr_en_i=1 and to standby when watch_tmr_en_i=0.
- R8: A sleep strobe in subactive with the software-standby bit at 1 moves the state to watch, whatever the value of watch_tmr_en_i.
- R9: A wakeup strobe has these effects:
  - sleep and standby return to active;
  - subsleep returns to subactive;
  - watch returns to active when low-speed-on is 0 and to subactive when it is 1.

  A wakeup in active or subactive has no effect. A sleep strobe in any low-power state has no effect.
- R10: main_clk_en_o is 1 only in active and sleep. sub_clk_en_o is 1 in every state except standby.
- R11: When a register write and a sleep strobe fall in the same cycle, the state choice uses the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register bus select |
| we_i | input | 1 | Register bus write enable |
| addr_i | input | 16 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| sleep_exec_i | input | 1 | One-cycle strobe: the core executed its sleep instruction |
| wakeup_i | input | 1 | One-cycle strobe: an interrupt or wakeup event |
| watch_tmr_en_i | input | 1 | Watch timer enabled; picks watch over standby from active |
| state_o | output | 3 | Current power state, encoded as in R1 |
| main_clk_en_o | output | 1 | Main clock enable |
| sub_clk_en_o | output | 1 | Sub clock enable |

## Verification
The bench drives a chain of sleep and wakeup steps that reaches all four sleep outcomes. A design that ignored the run mode or the watch-timer input would land in sleep or standby where watch or subsleep is due. The exit from watch is tried with low-speed-on both clear and set; a design that always returned to active could then never reach subactive. Other steps cover:
- strobes that must be ignored, where a wrong design would leave or re-enter a state;
- a register write that coincides with a sleep strobe, where a design reading the new value would pick standby instead of sleep;
- writes of 0 to the reserved bit, which must still read back as 1.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE = 3'd0,
    PS_SUBACT = 3'd1,
    PS_SLEEP  = 3'd2,
    PS_SUBSLP = 3'd3,
    PS_STBY   = 3'd4,
    PS_WATCH  = 3'd5
  } pstate_e;

  localparam int unsigned BIT_SSTBY  = 7;
  localparam int unsigned BIT_LOWSPD = 3;
  localparam int unsigned BIT_RSVD   = 2;
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hFFF0,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 16'hFFF1,
  parameter logic [DATA_W-1:0] CTL_RST  = 8'h07,
  parameter logic [DATA_W-1:0] AUX_RST  = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctl_o
);
  import lpm_pkg::*;

  localparam logic [DATA_W-1:0] RSVD_MASK = DATA_W'(1) << BIT_RSVD;

  logic [DATA_W-1:0] ctl_q, aux_q;
  logic              wr;

  assign wr = sel_i && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_RST | RSVD_MASK;
      aux_q <= AUX_RST;
    end else if (wr) begin
      if (addr_i == CTL_ADDR) ctl_q <= wdata_i | RSVD_MASK;
      if (addr_i == AUX_ADDR) aux_q <= wdata_i;
    end
  end

  always_comb begin
    if (addr_i == CTL_ADDR)      rdata_o = ctl_q;
    else if (addr_i == AUX_ADDR) rdata_o = aux_q;
    else                         rdata_o = '0;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              wake_i,
  input  logic              wte_i,
  input  logic              sstby_i,
  input  logic              lowspd_i,
  output lpm_pkg::pstate_e  state_o
);
  import lpm_pkg::*;

  pstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_ACTIVE: if (sleep_i) state_d = !sstby_i ? PS_SLEEP : (wte_i ? PS_WATCH : PS_STBY);
      PS_SUBACT: if (sleep_i) state_d = sstby_i ? PS_WATCH : PS_SUBSLP;
      PS_SLEEP,
      PS_STBY:   if (wake_i)  state_d = PS_ACTIVE;
      PS_SUBSLP: if (wake_i)  state_d = PS_SUBACT;
      PS_WATCH:  if (wake_i)  state_d = lowspd_i ? PS_SUBACT : PS_ACTIVE;
      default:                state_d = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PS_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lpm_clk_en.sv
module lpm_clk_en (
  input  lpm_pkg::pstate_e state_i,
  output logic             main_en_o,
  output logic             sub_en_o
);
  import lpm_pkg::*;

  assign main_en_o = (state_i == PS_ACTIVE) || (state_i == PS_SLEEP);
  assign sub_en_o  = (state_i != PS_STBY);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'hFFF0,
  parameter logic [ADDR_W-1:0] AUX_ADDR = 16'hFFF1,
  parameter logic [DATA_W-1:0] CTL_RST  = 8'h07,
  parameter logic [DATA_W-1:0] AUX_RST  = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sleep_exec_i,
  input  logic              wakeup_i,
  input  logic              watch_tmr_en_i,
  output logic [2:0]        state_o,
  output logic              main_clk_en_o,
  output logic              sub_clk_en_o
);
  import lpm_pkg::*;

  logic [DATA_W-1:0] ctl_q;
  pstate_e           state;

  lpm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_ADDR(CTL_ADDR),
    .AUX_ADDR(AUX_ADDR), .CTL_RST(CTL_RST), .AUX_RST(AUX_RST)
  ) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .ctl_o(ctl_q)
  );

  lpm_fsm u_fsm (
    .clk_i, .rst_ni,
    .sleep_i (sleep_exec_i),
    .wake_i  (wakeup_i),
    .wte_i   (watch_tmr_en_i),
    .sstby_i (ctl_q[BIT_SSTBY]),
    .lowspd_i(ctl_q[BIT_LOWSPD]),
    .state_o (state)
  );

  lpm_clk_en u_clk_en (
    .state_i  (state),
    .main_en_o(main_clk_en_o),
    .sub_en_o (sub_clk_en_o)
  );

  assign state_o = state;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter logic [15:0] CTL_ADDR = 16'hFFF0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sleep_exec_i,
  input logic        wakeup_i,
  input logic        watch_tmr_en_i,
  input logic        sstby,
  input logic        lowspd,
  input logic [15:0] addr_i,
  input logic [7:0]  rdata_o,
  input logic [2:0]  state_o,
  input logic        main_clk_en_o,
  input logic        sub_clk_en_o
);
  // R5
  sleep_from_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_exec_i && !sstby) |=> state_o == 3'd2);
  // R6
  subsleep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && sleep_exec_i && !sstby) |=> state_o == 3'd3);
  // R7
  watch_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_exec_i && sstby && watch_tmr_en_i) |=> state_o == 3'd5);
  // R7
  standby_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && sleep_exec_i && sstby && !watch_tmr_en_i) |=> state_o == 3'd4);
  // R8
  sub_watch_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 && sleep_exec_i && sstby) |=> state_o == 3'd5);
  // R9
  subsleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && wakeup_i) |=> state_o == 3'd1);
  // R9
  watch_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && wakeup_i) |=> state_o == (lowspd ? 3'd1 : 3'd0));
  // R9
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o <= 3'd1 && !sleep_exec_i) |=> $stable(state_o));
  // R10
  standby_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 |-> (!sub_clk_en_o && !main_clk_en_o));
  // R10
  sub_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd3 || state_o == 3'd5) |-> (sub_clk_en_o && !main_clk_en_o));
  // R3
  rsvd_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == CTL_ADDR |-> rdata_o[2]);
  // R1
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd5);
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk_i, .rst_ni, .sleep_exec_i, .wakeup_i, .watch_tmr_en_i,
  .sstby(ctl_q[7]), .lowspd(ctl_q[3]),
  .addr_i, .rdata_o, .state_o, .main_clk_en_o, .sub_clk_en_o
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        sleep_exec_i = 1'b0, wakeup_i = 1'b0, watch_tmr_en_i = 1'b0;
  logic [2:0]  state_o;
  logic        main_clk_en_o, sub_clk_en_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lpm_ctrl dut (
    .clk_i(clk), .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .sleep_exec_i, .wakeup_i, .watch_tmr_en_i, .state_o,
    .main_clk_en_o, .sub_clk_en_o
  );

  // Fields: [15] write, [14:7] wdata, [6] sleep, [5] wake, [4] wte, [2:0] expected state
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},  // clear control bits
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},  // R5
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},  // R9 sleep ignored
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R9
    {1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2},  // R11 old value used
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R9
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd4},  // R7 standby
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R9
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},  // R7 watch
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0},  // R9 low-speed 0
    {1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 3'd5},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},  // R9 low-speed 1
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},  // R9 wake ignored
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5},  // R8
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1},
    {1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3},  // R6
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1}   // R9
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic s);
    @(negedge clk);
    sel_i = s; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [15:0] a, input logic [7:0] exp);
    addr_i = a;
    #1;
    check(req, {8'h00, rdata_o}, {8'h00, exp});
  endtask

  // R10 expectation from the state encoding
  function automatic logic [15:0] pack_out(input logic [2:0] st);
    logic m, s;
    m = (st == 3'd0) || (st == 3'd2);
    s = (st != 3'd4);
    return {11'd0, st, m, s};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check("R1 state", {13'd0, state_o}, 16'd0);
    bus_read("R1 ctl", 16'hFFF0, 8'h07);
    bus_read("R1 aux", 16'hFFF1, 8'hF0);
    // R3: zero written to reserved bit
    bus_write(16'hFFF0, 8'h00, 1'b1);
    bus_read("R3 rsvd", 16'hFFF0, 8'h04);
    // R2
    bus_write(16'hFFF0, 8'h7B, 1'b1);
    bus_read("R2 ctl write", 16'hFFF0, 8'h7F);
    bus_write(16'hFFF0, 8'h00, 1'b0);
    bus_read("R2 sel low", 16'hFFF0, 8'h7F);
    bus_write(16'h1234, 8'hAA, 1'b1);
    bus_read("R2 unmapped", 16'h1234, 8'h00);
    bus_read("R2 unmapped write", 16'hFFF0, 8'h7F);
    // R4
    bus_write(16'hFFF1, 8'h5A, 1'b1);
    bus_read("R4 aux", 16'hFFF1, 8'h5A);
    bus_read("R4 ctl kept", 16'hFFF0, 8'h7F);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sel_i = VEC[i][15]; we_i = VEC[i][15]; addr_i = 16'hFFF0;
      wdata_i = VEC[i][14:7];
      sleep_exec_i = VEC[i][6]; wakeup_i = VEC[i][5]; watch_tmr_en_i = VEC[i][4];
      @(negedge clk);
      sel_i = 1'b0; we_i = 1'b0; sleep_exec_i = 1'b0; wakeup_i = 1'b0;
      check($sformatf("R5-step%0d R10", i),
            {11'd0, state_o, main_clk_en_o, sub_clk_en_o}, pack_out(VEC[i][2:0]));
    end

    // R1: reset from a low-power run state
    rst_ni = 1'b0;
    #1;
    check("R1 reset state", {13'd0, state_o}, 16'd0);
    bus_read("R1 reset ctl", 16'hFFF0, 8'h07);
    @(negedge clk);
    rst_ni = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule